// File: doc/BRIEF.md
# Shared Capture/Compare Timebase

This block is a 16-bit timebase that five capture/compare units share. The count advances on a single-cycle enable taken from one of four sources: the system clock divided by 12, the system clock divided by 4, a one-cycle pulse from a neighbouring timer's overflow, or rising edges of an asynchronous external input. A run bit starts and stops the count, and a freeze bit can hold it while the processor sits in its idle state. When the count wraps from all ones to zero, a sticky overflow flag is set. Only a software write clears that flag.

Each unit holds a 16-bit value and has a 5-bit configuration. In software-timer mode and in fast-output mode it flags the cycle in which the count reaches its value, and in fast-output mode it also toggles its output. In capture mode it copies the count into its value on a chosen edge of its own pin. In PWM mode it drives its output high while the low byte of the count is below the low byte of its value. All flags are collected in one control word, which also holds the run bit. A single interrupt line combines the flags with their enables. A watchdog-enable bit is passed straight to an output for the reset logic of unit 4.

Software writes the mode word, the control word, the count and each unit's configuration and value through separate write strobes. The count, the control word, all unit values and the unit outputs can be read back at all times.

Top module: `cc_timebase`

## Requirements
- R1: After reset, count, control word, unit values, unit outputs, irq and wdog_en are all zero.
- R2: With mode bits [2:1] = 00 and the run bit set, the count advances once every 12 clocks, the first increment landing 12 clocks after the run bit is written.
- R3: With mode bits [2:1] = 01, the count advances once every 4 clocks under the same timing.
- R4: With mode bits [2:1] = 10, the count advances once for each clock in which t0_ovf is high.
- R5: With mode bits [2:1] = 11, ext_clk is synchronized through two flops, and the count advances once for each rising edge whose high and low times each last at least two clocks.
- R6: While the run bit (control bit 5) is clear, the count holds its value, except when software loads it.
- R7: When mode bit 4 is set and cpu_idle is high, the count holds. When mode bit 4 is clear, cpu_idle has no effect.
- R8: A wrap from 16'hFFFF to 0 sets the overflow flag (control bit 6). The flag stays set until software writes it to 0. It drives irq only while mode bit 0 is set.
- R9: A unit in software-timer mode (configuration bits [1:0] = 01) sets its flag (control bit i for unit i) on the clock edge at which the count becomes equal to its value.
- R10: A unit in fast-output mode (bits [1:0] = 10) sets its flag on a match the same way, and it toggles its output at each match.
- R11: A unit in capture mode (bits [1:0] = 00) loads the count into its value and sets its flag on a synchronized rising pin edge when configuration bit 2 is set, or on a falling edge when bit 3 is set. An edge of a polarity that is not enabled leaves the value and the flag unchanged.
- R12: A unit in PWM mode (bits [1:0] = 11) drives its output high exactly while count[7:0] < value[7:0].
- R13: irq is also high while any unit flag is set and that unit's configuration bit 4 is set. Clearing the flag drops irq.
- R14: wdog_en follows mode bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Write strobe for the mode word |
| mode_wdata | input | 5 | Mode word: [4] idle freeze, [3] watchdog enable, [2:1] source, [0] overflow irq enable |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 7 | Control word: [6] overflow flag, [5] run, [4:0] unit flags |
| cnt_we | input | 1 | Load strobe for the count |
| cnt_wdata | input | 16 | Count load value |
| unit_sel | input | 3 | Unit addressed by the unit write strobes |
| ucfg_we | input | 1 | Write strobe for the selected unit's configuration |
| ucfg_wdata | input | 5 | Unit configuration: [4] irq enable, [3] capture on fall, [2] capture on rise, [1:0] mode |
| uval_we | input | 1 | Write strobe for the selected unit's value |
| uval_wdata | input | 16 | Unit value to write |
| cpu_idle | input | 1 | Processor idle indication |
| t0_ovf | input | 1 | One-cycle overflow pulse from a neighbouring timer |
| ext_clk | input | 1 | Asynchronous external count input |
| unit_pin | input | 5 | Asynchronous capture pins, one per unit |
| count | output | 16 | Current count |
| ctl_q | output | 7 | Control word readback |
| unit_val | output | 80 | Unit values, unit i in bits [16*i+15:16*i] |
| unit_out | output | 5 | Unit outputs (fast-output toggle or PWM) |
| irq | output | 1 | Combined interrupt request |
| wdog_en | output | 1 | Watchdog enable for unit 4 |

## Verification
The overflow case is the hardest to reach from the ports. At the default rates a wrap needs tens of thousands of divided clocks. The stimulus therefore stops the counter, loads it with 16'hFFFD and switches to the neighbouring-timer source, so that three hand-placed t0_ovf pulses cross the wrap in a known cycle. Capture values are made deterministic by stopping the counter and loading a known count before the pin edge is driven. The synchronizer latency then has no effect on the captured value. A pin edge of the disabled polarity is always placed between two enabled ones, so a wrongly taken capture would show up as a changed value.

// File: rtl/cc_pkg.sv
package cc_pkg;

    localparam int CNT_W    = 16;
    localparam int UNITS    = 5;
    localparam int DIV_SLOW = 12;
    localparam int DIV_FAST = 4;
    localparam int PWM_W    = 8;

    typedef enum logic [1:0] {
        SRC_DIV_SLOW = 2'b00,
        SRC_DIV_FAST = 2'b01,
        SRC_T0       = 2'b10,
        SRC_EXT      = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        UM_CAPTURE = 2'b00,
        UM_TIMER   = 2'b01,
        UM_FASTOUT = 2'b10,
        UM_PWM     = 2'b11
    } umode_e;

    typedef struct packed {
        logic idle_freeze;
        logic wdog;
        src_e src;
        logic ovf_ie;
    } mode_reg_t;

    typedef struct packed {
        logic   irq_en;
        logic   cap_fall;
        logic   cap_rise;
        umode_e mode;
    } ucfg_t;

    function automatic logic is_divider(src_e s);
        return (s == SRC_DIV_SLOW) || (s == SRC_DIV_FAST);
    endfunction

    function automatic logic is_matching(umode_e m);
        return (m == UM_TIMER) || (m == UM_FASTOUT);
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cc_prescale.sv
module cc_prescale
    import cc_pkg::*;
#(
    parameter int DIV_SLOW = cc_pkg::DIV_SLOW,
    parameter int DIV_FAST = cc_pkg::DIV_FAST,
    localparam int PW = $clog2(max2(DIV_SLOW, DIV_FAST))
)(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic freeze,
    input  src_e src,
    input  logic t0_pulse,
    input  logic ext_in,
    output logic tick
);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] limit;
    logic [2:0]    ext_sync;
    logic          ext_rise;
    logic          pre_hit;
    logic          src_pulse;

    always_comb limit = (src == SRC_DIV_FAST) ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);

    assign pre_hit  = (pre_q >= limit);
    assign ext_rise = ext_sync[1] & ~ext_sync[2];

    always_comb begin
        case (src)
            SRC_DIV_SLOW: src_pulse = pre_hit;
            SRC_DIV_FAST: src_pulse = pre_hit;
            SRC_T0:       src_pulse = t0_pulse;
            default:      src_pulse = ext_rise;
        endcase
    end

    assign tick = run & ~freeze & src_pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q    <= '0;
            ext_sync <= '0;
        end else begin
            ext_sync <= {ext_sync[1:0], ext_in};
            if (!run)
                pre_q <= '0;
            else if (!freeze)
                pre_q <= pre_hit ? '0 : pre_q + PW'(1);
        end
    end

    AST_DIV_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick && is_divider(src)) |=> (!tick || !is_divider(src)))
        else $error("divided tick repeated"); // R2

endmodule

// File: rtl/cc_counter.sv
module cc_counter
#(
    parameter int CNT_W = cc_pkg::CNT_W
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cnt_next,
    output logic             adv,
    output logic             ovf
);

    logic [CNT_W-1:0] cnt_q;

    assign count    = cnt_q;
    assign cnt_next = cnt_q + CNT_W'(1);
    assign adv      = tick & ~load;
    assign ovf      = adv & (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick)
            cnt_q <= cnt_next;
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_q))
        else $error("count moved without tick"); // R6

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (cnt_q == '0))
        else $error("overflow did not wrap to zero"); // R8

endmodule

// File: rtl/cc_unit.sv
module cc_unit
    import cc_pkg::*;
#(
    parameter int CNT_W = cc_pkg::CNT_W,
    parameter int PWM_W = cc_pkg::PWM_W
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  ucfg_t            cfg_wdata,
    input  logic             val_we,
    input  logic [CNT_W-1:0] val_wdata,
    input  logic             pin,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic             adv,
    output logic [CNT_W-1:0] val,
    output logic             hit,
    output logic             irq_en,
    output logic             out
);

    ucfg_t            cfg_q;
    logic [CNT_W-1:0] val_q;
    logic [2:0]       pin_sync;
    logic             out_q;
    logic             rise, fall, cap, match;

    assign rise  = pin_sync[1] & ~pin_sync[2];
    assign fall  = ~pin_sync[1] & pin_sync[2];
    assign cap   = (cfg_q.mode == UM_CAPTURE) &&
                   ((rise && cfg_q.cap_rise) || (fall && cfg_q.cap_fall));
    assign match = adv && (cnt_next == val_q) && is_matching(cfg_q.mode);

    assign hit    = cap | match;
    assign val    = val_q;
    assign irq_en = cfg_q.irq_en;
    assign out    = out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            val_q    <= '0;
            pin_sync <= '0;
            out_q    <= 1'b0;
        end else begin
            pin_sync <= {pin_sync[1:0], pin};
            if (cfg_we)
                cfg_q <= cfg_wdata;
            if (cap)
                val_q <= count;
            else if (val_we)
                val_q <= val_wdata;
            case (cfg_q.mode)
                UM_FASTOUT: if (match) out_q <= ~out_q;
                UM_PWM:     out_q <= (count[PWM_W-1:0] < val_q[PWM_W-1:0]);
                default:    out_q <= 1'b0;
            endcase
        end
    end

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
        cap |=> (val_q == $past(count)))
        else $error("capture value wrong"); // R11

    AST_NO_STRAY_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode != UM_CAPTURE && !val_we) |=> $stable(val_q))
        else $error("value changed outside capture"); // R11

    AST_FASTOUT_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == UM_FASTOUT && match) |=> (out_q != $past(out_q)))
        else $error("fast output did not toggle"); // R10

endmodule

// File: rtl/cc_timebase.sv
module cc_timebase
    import cc_pkg::*;
#(
    parameter int CNT_W    = cc_pkg::CNT_W,
    parameter int UNITS    = cc_pkg::UNITS,
    parameter int DIV_SLOW = cc_pkg::DIV_SLOW,
    parameter int DIV_FAST = cc_pkg::DIV_FAST,
    localparam int SEL_W   = $clog2(UNITS),
    localparam int CTL_W   = UNITS + 2,
    localparam int MODE_W  = $bits(mode_reg_t),
    localparam int UCFG_W  = $bits(ucfg_t)
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mode_we,
    input  logic [MODE_W-1:0]      mode_wdata,
    input  logic                   ctl_we,
    input  logic [CTL_W-1:0]       ctl_wdata,
    input  logic                   cnt_we,
    input  logic [CNT_W-1:0]       cnt_wdata,
    input  logic [SEL_W-1:0]       unit_sel,
    input  logic                   ucfg_we,
    input  logic [UCFG_W-1:0]      ucfg_wdata,
    input  logic                   uval_we,
    input  logic [CNT_W-1:0]       uval_wdata,
    input  logic                   cpu_idle,
    input  logic                   t0_ovf,
    input  logic                   ext_clk,
    input  logic [UNITS-1:0]       unit_pin,
    output logic [CNT_W-1:0]       count,
    output logic [CTL_W-1:0]       ctl_q,
    output logic [UNITS*CNT_W-1:0] unit_val,
    output logic [UNITS-1:0]       unit_out,
    output logic                   irq,
    output logic                   wdog_en
);

    mode_reg_t        mode_q;
    logic             run_q, cf_q;
    logic [UNITS-1:0] flags_q;
    logic [UNITS-1:0] hits, unit_ie;
    logic             tick, adv, ovf, freeze;
    logic [CNT_W-1:0] cnt_w, cnt_next;

    assign freeze = mode_q.idle_freeze & cpu_idle;

    cc_prescale #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .run      (run_q),
        .freeze   (freeze),
        .src      (mode_q.src),
        .t0_pulse (t0_ovf),
        .ext_in   (ext_clk),
        .tick     (tick)
    );

    cc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (cnt_we),
        .load_val (cnt_wdata),
        .count    (cnt_w),
        .cnt_next (cnt_next),
        .adv      (adv),
        .ovf      (ovf)
    );

    for (genvar i = 0; i < UNITS; i++) begin : g_unit
        cc_unit #(.CNT_W(CNT_W)) u_unit (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (ucfg_we && (unit_sel == SEL_W'(i))),
            .cfg_wdata (ucfg_t'(ucfg_wdata)),
            .val_we    (uval_we && (unit_sel == SEL_W'(i))),
            .val_wdata (uval_wdata),
            .pin       (unit_pin[i]),
            .count     (cnt_w),
            .cnt_next  (cnt_next),
            .adv       (adv),
            .val       (unit_val[i*CNT_W +: CNT_W]),
            .hit       (hits[i]),
            .irq_en    (unit_ie[i]),
            .out       (unit_out[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            run_q   <= 1'b0;
            cf_q    <= 1'b0;
            flags_q <= '0;
        end else begin
            if (mode_we)
                mode_q <= mode_reg_t'(mode_wdata);
            if (ctl_we) begin
                cf_q    <= ctl_wdata[CTL_W-1] | ovf;
                run_q   <= ctl_wdata[CTL_W-2];
                flags_q <= ctl_wdata[UNITS-1:0] | hits;
            end else begin
                cf_q    <= cf_q | ovf;
                flags_q <= flags_q | hits;
            end
        end
    end

    assign count   = cnt_w;
    assign ctl_q   = {cf_q, run_q, flags_q};
    assign irq     = (cf_q & mode_q.ovf_ie) | (|(flags_q & unit_ie));
    assign wdog_en = mode_q.wdog;

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        ovf |=> cf_q)
        else $error("overflow flag not set"); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (cf_q && !ctl_we) |=> cf_q)
        else $error("overflow flag dropped by hardware"); // R8

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (hits != '0) |=> ((flags_q & $past(hits)) == $past(hits)))
        else $error("unit flag not set"); // R9

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !cnt_we) |=> $stable(cnt_w))
        else $error("count moved while stopped"); // R6

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!cf_q && flags_q == '0) |-> !irq)
        else $error("irq without a flag"); // R13

endmodule

// File: tb/cc_timebase_bench.sv
module cc_timebase_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        mode_we = 0, ctl_we = 0, cnt_we = 0, ucfg_we = 0, uval_we = 0;
    logic [4:0]  mode_wdata = 0, ucfg_wdata = 0;
    logic [6:0]  ctl_wdata = 0;
    logic [15:0] cnt_wdata = 0, uval_wdata = 0;
    logic [2:0]  unit_sel = 0;
    logic        cpu_idle = 0, t0_ovf = 0, ext_clk = 0;
    logic [4:0]  unit_pin = 0;
    logic [15:0] count;
    logic [6:0]  ctl_q;
    logic [79:0] unit_val;
    logic [4:0]  unit_out;
    logic        irq, wdog_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    cc_timebase u_cc_timebase (
        .clk(clk), .rst(rst),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .unit_sel(unit_sel), .ucfg_we(ucfg_we), .ucfg_wdata(ucfg_wdata),
        .uval_we(uval_we), .uval_wdata(uval_wdata),
        .cpu_idle(cpu_idle), .t0_ovf(t0_ovf), .ext_clk(ext_clk),
        .unit_pin(unit_pin),
        .count(count), .ctl_q(ctl_q), .unit_val(unit_val),
        .unit_out(unit_out), .irq(irq), .wdog_en(wdog_en)
    );

    // {source[7:0], clocks[15:0], expected count[7:0]}
    localparam logic [31:0] VEC [6] = '{
        32'h00_0078_0A, 32'h00_002F_03, 32'h00_000C_01,
        32'h01_0028_0A, 32'h01_000D_03, 32'h01_0003_00
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic wr_mode(input logic [4:0] d);
        mode_wdata = d; mode_we = 1; @(negedge clk); mode_we = 0;
    endtask
    task automatic wr_ctl(input logic [6:0] d);
        ctl_wdata = d; ctl_we = 1; @(negedge clk); ctl_we = 0;
    endtask
    task automatic wr_cnt(input logic [15:0] d);
        cnt_wdata = d; cnt_we = 1; @(negedge clk); cnt_we = 0;
    endtask
    task automatic wr_ucfg(input logic [2:0] s, input logic [4:0] d);
        unit_sel = s; ucfg_wdata = d; ucfg_we = 1; @(negedge clk); ucfg_we = 0;
    endtask
    task automatic wr_uval(input logic [2:0] s, input logic [15:0] d);
        unit_sel = s; uval_wdata = d; uval_we = 1; @(negedge clk); uval_we = 0;
    endtask
    task automatic t0_pulses(input int n);
        for (int k = 0; k < n; k++) begin
            t0_ovf = 1; @(negedge clk); t0_ovf = 0; @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        chk("R1 count", count, 0);
        chk("R1 ctl", ctl_q, 0);
        chk("R1 values", unit_val[31:0] | unit_val[63:32] | {16'h0, unit_val[79:64]}, 0);
        chk("R1 outs/irq/wdog", {unit_out, irq, wdog_en}, 0);

        // R2 R3: divided sources from the vector table
        for (int v = 0; v < 6; v++) begin
            wr_ctl(7'h00);
            wr_cnt(16'h0);
            wr_mode({2'b00, VEC[v][25:24], 1'b0});
            wr_ctl(7'h20);
            repeat (int'(VEC[v][23:8])) @(negedge clk);
            chk(VEC[v][24] ? "R3 divide by 4" : "R2 divide by 12", count, {24'h0, VEC[v][7:0]});
        end

        // R7 idle freeze
        wr_ctl(7'h00); wr_cnt(16'h0);
        cpu_idle = 1;
        wr_mode(5'h12);
        wr_ctl(7'h20);
        repeat (40) @(negedge clk);
        chk("R7 frozen in idle", count, 0);
        wr_mode(5'h02);
        repeat (40) @(negedge clk);
        chk("R7 idle ignored when freeze bit clear", count, 10);
        cpu_idle = 0;

        // R6 stop
        wr_ctl(7'h00);
        held = count;
        repeat (30) @(negedge clk);
        chk("R6 stopped count holds", count, held);

        // R4 neighbour timer pulses
        wr_cnt(16'h0); wr_mode(5'h04); wr_ctl(7'h20);
        t0_pulses(7);
        chk("R4 t0 pulses", count, 7);

        // R5 external input
        wr_ctl(7'h00); wr_cnt(16'h0); wr_mode(5'h06); wr_ctl(7'h20);
        for (int k = 0; k < 5; k++) begin
            ext_clk = 1; repeat (3) @(negedge clk);
            ext_clk = 0; repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk("R5 external edges", count, 5);

        // R8 overflow
        wr_ctl(7'h00); wr_cnt(16'hFFFD); wr_mode(5'h04); wr_ctl(7'h20);
        t0_pulses(2);
        chk("R8 no flag before wrap", {count, ctl_q[6]}, {16'hFFFF, 1'b0});
        t0_pulses(1);
        chk("R8 flag on wrap", {count, ctl_q[6], irq}, {16'h0000, 1'b1, 1'b0});
        wr_mode(5'h05);
        chk("R8 irq with enable", irq, 1);
        repeat (10) @(negedge clk);
        chk("R8 flag sticky", ctl_q[6], 1);
        wr_ctl(7'h20);
        chk("R8 software clear", {ctl_q, irq}, {7'h20, 1'b0});

        // R9 software timer match, R13 unit irq
        wr_ctl(7'h00); wr_cnt(16'h0); wr_mode(5'h04);
        wr_ucfg(3'd1, 5'h01); wr_uval(3'd1, 16'd5);
        wr_ctl(7'h20);
        t0_pulses(4);
        chk("R9 no flag before match", ctl_q[1], 0);
        t0_pulses(1);
        chk("R9 flag on match", {ctl_q[1], irq}, {1'b1, 1'b0});
        wr_ucfg(3'd1, 5'h11);
        chk("R13 unit irq", irq, 1);
        wr_ctl(7'h20);
        chk("R13 irq drops with flag", irq, 0);

        // R10 fast output
        wr_ucfg(3'd2, 5'h02); wr_uval(3'd2, 16'd8);
        t0_pulses(3);
        chk("R10 toggle high and flag", {count, unit_out[2], ctl_q[2]}, {16'd8, 1'b1, 1'b1});
        t0_pulses(1);
        chk("R10 holds between matches", unit_out[2], 1);
        wr_cnt(16'd7);
        t0_pulses(1);
        chk("R10 toggle low", unit_out[2], 0);

        // R11 capture
        wr_ctl(7'h00);
        wr_ucfg(3'd3, 5'h04);
        wr_cnt(16'h1234);
        unit_pin[3] = 1; repeat (5) @(negedge clk);
        chk("R11 rising capture", {unit_val[63:48], 15'h0, ctl_q[3]}, {16'h1234, 16'h1});
        wr_ctl(7'h00); wr_cnt(16'h5555);
        unit_pin[3] = 0; repeat (5) @(negedge clk);
        chk("R11 falling ignored", {unit_val[63:48], 15'h0, ctl_q[3]}, {16'h1234, 16'h0});
        wr_ucfg(3'd3, 5'h08); wr_cnt(16'h7777);
        unit_pin[3] = 1; repeat (5) @(negedge clk);
        chk("R11 rising ignored", {unit_val[63:48], 15'h0, ctl_q[3]}, {16'h1234, 16'h0});
        unit_pin[3] = 0; repeat (5) @(negedge clk);
        chk("R11 falling capture", {unit_val[63:48], 15'h0, ctl_q[3]}, {16'h7777, 16'h1});

        // R12 PWM
        wr_ucfg(3'd4, 5'h03); wr_uval(3'd4, 16'h0020); wr_cnt(16'h0010);
        repeat (2) @(negedge clk);
        chk("R12 pwm high below value", unit_out[4], 1);
        wr_uval(3'd4, 16'h0005);
        repeat (2) @(negedge clk);
        chk("R12 pwm low above value", unit_out[4], 0);

        // R14 watchdog enable
        wr_mode(5'h0C);
        chk("R14 watchdog enable", wdog_en, 1);

        done = 1;
        summary();
        $finish;
    end

endmodule